// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by letting a per-address chooser pick between two component predictors. The first component keeps a short outcome history for each branch address. That history selects one of many 3-bit saturating counters. The second component keeps a single shift register of the most recent outcomes across all branches. That register selects one of many 2-bit saturating counters. The chooser is a table of 2-bit saturating counters, indexed by the branch address, that tracks which component has been more reliable for that address.

The prediction side is purely combinational. A fetch PC goes in and the final guess comes out in the same cycle, together with both component guesses. The fetch stage carries the two component guesses down the pipeline. When a branch resolves, the pipeline presents the branch PC, the real outcome and the two carried guesses on the update side. On the next clock edge the block then trains the local counter, the global counter, the per-branch history, the global history and, when needed, the chooser. Updates must arrive in program order. The block does not predict targets and does not repair speculative history.

Top module: `tourney_predictor`

## Requirements
- R1: After a synchronous active-low reset, every PC predicts not-taken from both components and overall. The global history and all per-branch histories are zero. Every chooser entry weakly prefers the local component (value 1).
- R2: The global guess is the top bit of a 2-bit counter, so it is taken at values 2 and 3. That counter comes from a table of 2^GHIST_W entries, indexed only by the global history register.
- R3: The local guess is the top bit of a 3-bit counter, so it is taken at values 4 to 7. That counter comes from a table indexed by the per-branch history, which is read from a history table indexed by PC[LHT_IDX_W+1:2].
- R4: The chooser entry at PC[CH_IDX_W+1:2] selects the output. At a value of 2 or more, pred_taken equals the global guess; below 2 it equals the local guess. PC bits [1:0] have no effect.
- R5: Every counter steps up on a taken update and down on a not-taken update, and holds at 0 and at its maximum.
- R6: A chooser entry changes only when upd_local_pred and upd_global_pred differ. It then steps toward the global side if the global guess matched the outcome, and toward the local side otherwise.
- R7: On each update, the global history and the updated branch's local history both shift left by one, and the outcome (1 taken, 0 not-taken) enters at bit 0.
- R8: An update changes a prediction read in the same cycle only from the following cycle.
- R9: While upd_valid is low, no prediction changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Final direction guess |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | PC_W | PC of resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local_pred | input | 1 | Local guess captured at predict time |
| upd_global_pred | input | 1 | Global guess captured at predict time |

## Verification
The bench uses small table sizes and, after each step, sweeps every chooser and history index. It compares all three outputs against an arithmetic model. A repeating taken-taken-taken-not-taken loop on one branch shows how the local history pattern training differs from the global counters. Long same-direction runs push counters into both saturation limits. Updates that carry agreeing but wrong guesses show that the chooser does not move. A pseudo-random mix of PCs and outcomes, together with same-cycle predict/update pairs and idle cycles with junk inputs, separates the visibility rule and the update enable from ordinary training.

// File: rtl/tp_pkg.sv
// Shared helpers for the tournament predictor.
// Assumes counter widths of at most 8 bits.
package tp_pkg;

    // Saturating step of an up/down counter bounded by 0 and vmax.
    function automatic logic [7:0] sat_step(input logic [7:0] v,
                                            input logic       up,
                                            input logic [7:0] vmax);
        if (up) return (v == vmax) ? v : v + 8'd1;
        else    return (v == 8'd0) ? v : v - 8'd1;
    endfunction

endpackage

// File: rtl/tp_table.sv
// Register-file table with two combinational read ports and one synchronous
// write port. Port A serves prediction and port B the update read-modify-write.
// Reads return the stored value, so a write becomes visible one cycle later.
// Assumes a synchronous active-low reset that loads every entry with RST_VAL.
module tp_table #(
    parameter int IDX_W   = 10,
    parameter int DATA_W  = 2,
    parameter int RST_VAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_val,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_val,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: reset all entries, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(RST_VAL);
        end else if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Read ports: plain lookups of the stored state.
    always_comb begin
        rd_a_val = mem[rd_a_idx];
        rd_b_val = mem[rd_b_idx];
    end
endmodule

// File: rtl/tp_ghist.sv
// Global outcome shift register. Each accepted update shifts the outcome
// in at bit 0. Assumes updates arrive in program order.
module tp_ghist #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);
    // History register: clear on reset, shift on each update.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[W-2:0], bit_in};
    end

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(bit_in)) && (hist[W-1:1] == $past(hist[W-2:0]))); // R7
    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist)); // R9
endmodule

// File: rtl/tourney_predictor.sv
// Tournament branch direction predictor. A per-address chooser picks
// between a two-level local predictor and a global-history predictor.
// Prediction is combinational. Training happens on the clock edge after
// upd_valid. Assumes in-order updates whose component guesses are the
// ones returned at predict time.
module tourney_predictor #(
    parameter int PC_W      = 32,
    parameter int CH_IDX_W  = 12,
    parameter int GHIST_W   = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int LCTR_W    = 3,
    parameter int GCTR_W    = 2,
    parameter int CHCTR_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local_pred,
    input  logic            upd_global_pred
);
    import tp_pkg::*;

    localparam int LMAX = (1 << LCTR_W) - 1;
    localparam int LRST = (1 << (LCTR_W - 1)) - 1;
    localparam int GMAX = (1 << GCTR_W) - 1;
    localparam int GRST = (1 << (GCTR_W - 1)) - 1;
    localparam int CMAX = (1 << CHCTR_W) - 1;
    localparam int CRST = (1 << (CHCTR_W - 1)) - 1;

    logic [GHIST_W-1:0]   ghist;
    logic [LHIST_W-1:0]   p_lhist, u_lhist, lhist_next;
    logic [LCTR_W-1:0]    p_lctr, u_lctr, lctr_next;
    logic [GCTR_W-1:0]    p_gctr, u_gctr, gctr_next;
    logic [CHCTR_W-1:0]   p_ch, u_ch, ch_next;
    logic [LHT_IDX_W-1:0] p_lidx, u_lidx;
    logic [CH_IDX_W-1:0]  p_cidx, u_cidx;
    logic                 disagree;
    logic [2*PC_W-1:0]    pc_bits_unused;

    assign pc_bits_unused = {pred_pc, upd_pc};

    // Index selection: word-aligned PC bits above the 2-bit offset.
    always_comb begin
        p_lidx = pred_pc[LHT_IDX_W+1:2];
        u_lidx = upd_pc[LHT_IDX_W+1:2];
        p_cidx = pred_pc[CH_IDX_W+1:2];
        u_cidx = upd_pc[CH_IDX_W+1:2];
    end

    // Per-branch local history table.
    tp_table #(.IDX_W(LHT_IDX_W), .DATA_W(LHIST_W), .RST_VAL(0)) lht_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(p_lidx), .rd_a_val(p_lhist),
        .rd_b_idx(u_lidx), .rd_b_val(u_lhist),
        .wr_en(upd_valid), .wr_idx(u_lidx), .wr_val(lhist_next));

    // Local pattern counters, indexed by the per-branch history.
    tp_table #(.IDX_W(LHIST_W), .DATA_W(LCTR_W), .RST_VAL(LRST)) lpt_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(p_lhist), .rd_a_val(p_lctr),
        .rd_b_idx(u_lhist), .rd_b_val(u_lctr),
        .wr_en(upd_valid), .wr_idx(u_lhist), .wr_val(lctr_next));

    // Global pattern counters, indexed by the global history.
    tp_table #(.IDX_W(GHIST_W), .DATA_W(GCTR_W), .RST_VAL(GRST)) gpt_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ghist), .rd_a_val(p_gctr),
        .rd_b_idx(ghist), .rd_b_val(u_gctr),
        .wr_en(upd_valid), .wr_idx(ghist), .wr_val(gctr_next));

    // Chooser counters, written only when the components disagreed.
    tp_table #(.IDX_W(CH_IDX_W), .DATA_W(CHCTR_W), .RST_VAL(CRST)) cht_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(p_cidx), .rd_a_val(p_ch),
        .rd_b_idx(u_cidx), .rd_b_val(u_ch),
        .wr_en(upd_valid && disagree), .wr_idx(u_cidx), .wr_val(ch_next));

    // Global history shift register.
    tp_ghist #(.W(GHIST_W)) gh_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist));

    // Prediction: counter top bits, chooser top bit picks the component.
    always_comb begin
        pred_local  = p_lctr[LCTR_W-1];
        pred_global = p_gctr[GCTR_W-1];
        pred_taken  = p_ch[CHCTR_W-1] ? pred_global : pred_local;
    end

    // Training values: saturating steps and history shift.
    always_comb begin
        disagree   = upd_local_pred != upd_global_pred;
        lhist_next = {u_lhist[LHIST_W-2:0], upd_taken};
        lctr_next  = LCTR_W'(sat_step(8'(u_lctr), upd_taken, 8'(LMAX)));
        gctr_next  = GCTR_W'(sat_step(8'(u_gctr), upd_taken, 8'(GMAX)));
        ch_next    = CHCTR_W'(sat_step(8'(u_ch), upd_global_pred == upd_taken, 8'(CMAX)));
    end

    AST_PICK_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local)); // R4
    AST_GCTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && u_gctr == GCTR_W'(GMAX)) |-> (gctr_next == GCTR_W'(GMAX))); // R5
    AST_LCTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && u_lctr == '0) |-> (lctr_next == '0)); // R5
    AST_CH_TOWARD_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && disagree && upd_global_pred == upd_taken) |-> (ch_next >= u_ch)); // R6
    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (lhist_next[0] == upd_taken)); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && $stable(pred_pc)) |-> $stable({pred_taken, pred_local, pred_global})); // R9
endmodule

// File: tb/tourney_predictor_tb_top.sv
// Bench for a small configuration, comparing the outputs with an arithmetic model.
module tourney_predictor_tb_top;
    localparam int PC_W = 8, CHW = 3, GHW = 3, LIW = 2, LHW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic pred_taken, pred_local, pred_global;
    logic upd_valid = 1'b0, upd_taken = 1'b0, upd_lp = 1'b0, upd_gp = 1'b0;

    int errs = 0, checks = 0;
    bit done = 0;
    int m_ch[1<<CHW], m_gp[1<<GHW], m_lp[1<<LHW], m_lht[1<<LIW];
    int m_gh;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;  // 125 MHz

    tourney_predictor #(.PC_W(PC_W), .CH_IDX_W(CHW), .GHIST_W(GHW),
        .LHT_IDX_W(LIW), .LHIST_W(LHW), .LCTR_W(3), .GCTR_W(2), .CHCTR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local_pred(upd_lp),
        .upd_global_pred(upd_gp));

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v == mx) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    function automatic bit m_loc(int pc);
        return m_lp[m_lht[(pc >> 2) % (1<<LIW)]] >= 4;
    endfunction
    function automatic bit m_glo();
        return m_gp[m_gh] >= 2;
    endfunction
    function automatic bit m_tk(int pc);
        return (m_ch[(pc >> 2) % (1<<CHW)] >= 2) ? m_glo() : m_loc(pc);
    endfunction

    task automatic model_reset();
        foreach (m_ch[i]) m_ch[i] = 1;
        foreach (m_gp[i]) m_gp[i] = 1;
        foreach (m_lp[i]) m_lp[i] = 3;
        foreach (m_lht[i]) m_lht[i] = 0;
        m_gh = 0;
    endtask

    task automatic model_update(int pc, bit t, bit lp, bit gp);
        int li, lh, ci;
        li = (pc >> 2) % (1<<LIW);
        lh = m_lht[li];
        m_lp[lh] = sat(m_lp[lh], t, 7);
        m_lht[li] = ((lh << 1) | int'(t)) % (1<<LHW);
        m_gp[m_gh] = sat(m_gp[m_gh], t, 3);
        m_gh = ((m_gh << 1) | int'(t)) % (1<<GHW);
        if (lp != gp) begin
            ci = (pc >> 2) % (1<<CHW);
            m_ch[ci] = sat(m_ch[ci], gp == t, 3);
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Sweep every chooser/history index; low PC bits vary to cover R4.
    task automatic sweep(string ctx);
        for (int i = 0; i < (1<<CHW); i++) begin
            pred_pc = PC_W'((i << 2) | (i & 3));
            #1;
            chk({"R2 ", ctx}, pred_global, m_glo());
            chk({"R3 ", ctx}, pred_local, m_loc(int'(pred_pc)));
            chk({"R4 ", ctx}, pred_taken, m_tk(int'(pred_pc)));
        end
    endtask

    task automatic upd_raw(int pc, bit t, bit lp, bit gp);
        @(negedge clk);
        upd_pc = PC_W'(pc); upd_taken = t; upd_lp = lp; upd_gp = gp; upd_valid = 1'b1;
        @(posedge clk); #1;
        upd_valid = 1'b0;
        model_update(pc, t, lp, gp);
    endtask

    task automatic upd(int pc, bit t);
        upd_raw(pc, t, m_loc(pc), m_glo());
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep("R1 reset");
        // R3 R7: loop-like TTTN pattern on one branch
        for (int k = 0; k < 24; k++) begin
            upd(16, (k % 4) != 3);
            sweep("R7 loop");
        end
        // R5: drive to both saturation limits
        for (int k = 0; k < 10; k++) upd(8, 1'b1);
        sweep("R5 high");
        for (int k = 0; k < 12; k++) upd(8, 1'b0);
        sweep("R5 low");
        // R6: agreeing guesses, both wrong, leave the chooser alone
        for (int k = 0; k < 4; k++) upd_raw(4, k[0], ~k[0], ~k[0]);
        sweep("R6 agree");
        // R6: disagreeing guesses move the chooser
        for (int k = 0; k < 4; k++) upd_raw(4, 1'b1, 1'b0, 1'b1);
        sweep("R6 toward global");
        for (int k = 0; k < 4; k++) upd_raw(12, 1'b0, 1'b0, 1'b1);
        sweep("R6 toward local");
        // R9: junk on update inputs while upd_valid is low
        @(negedge clk);
        upd_pc = 8'h1C; upd_taken = 1'b1; upd_lp = 1'b0; upd_gp = 1'b1;
        repeat (5) @(posedge clk);
        #1 sweep("R9 idle");
        // R8: same-cycle predict/update pairs
        for (int k = 0; k < 6; k++) begin
            int pc;
            bit t, lp, gp;
            pc = (k % 8) << 2;
            t = 1'b1;
            @(negedge clk);
            lp = m_loc(pc); gp = m_glo();
            pred_pc = PC_W'(pc);
            upd_pc = PC_W'(pc); upd_taken = t; upd_lp = lp; upd_gp = gp; upd_valid = 1'b1;
            #1;
            chk("R8 before edge local", pred_local, m_loc(pc));
            chk("R8 before edge global", pred_global, m_glo());
            chk("R8 before edge taken", pred_taken, m_tk(pc));
            @(posedge clk); #1;
            upd_valid = 1'b0;
            model_update(pc, t, lp, gp);
            chk("R8 after edge local", pred_local, m_loc(pc));
            chk("R8 after edge global", pred_global, m_glo());
            chk("R8 after edge taken", pred_taken, m_tk(pc));
        end
        // Mixed pseudo-random traffic
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            upd(int'(lfsr[7:0]), lfsr[9] | lfsr[11]);
            if (k % 8 == 7) sweep("R5 mixed");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule